// File: doc/BRIEF.md
# Watchdog Control Register with NMI Routing

This block holds the 16-bit control word of a system watchdog and management unit. Software writes the word over a simple synchronous write port and reads it back combinationally. The stored fields drive four kinds of control: an inhibit for the separately held watchdog enable, a halt for the watchdog counter and its message traffic, a redirect that steers NMI events toward the SMI output, and a software-forced NMI request.

Incoming NMI event pulses are routed to a registered NMI output or a registered SMI output. The choice depends on the redirect field and two outside enables: an NMI permit input (1 lets NMI events through) and a global SMI enable. The lock field can be set by software and is cleared only by the core reset. The forced-NMI field raises one NMI when set and is cleared by writing 1 to it again. A new forced NMI is only possible after that clear.

Top module: `wdog_ctl_reg`

## Requirements
- R1: After the active-low core reset `rst_n`, `rd_data` reads 0x0000, and `nmi_out`, `smi_out` and `wden_wr_inhibit` are 0.
- R2: Bit 12 (lock) is set by writing 1 to it. Writing 0 never clears it, and only `rst_n` does. `wden_wr_inhibit` equals the lock bit.
- R3: While bit 11 (halt) is 1, `cnt_tick_out`, `reboot_out` and `evmsg_out` are forced to 0. `heartbeat_out` always follows `heartbeat_in`. While halt is 0, all four outputs follow their inputs combinationally.
- R4: With bit 9 (redirect) at 0, an `nmi_event_in` high on a clock edge makes `nmi_out` high for the following cycle exactly when `nmi_allow` is 1. `smi_out` stays 0.
- R5: With redirect at 1 and `smi_global_en` at 0, an NMI event produces neither `smi_out` nor `nmi_out`.
- R6: With redirect at 1 and `smi_global_en` at 1, an NMI event makes `smi_out` high for the following cycle exactly when `nmi_allow` is 1. `nmi_out` stays 0.
- R7: A write with bit 8 (force) at 1 while force is 0 sets force and makes `nmi_out` high for exactly the one cycle after that write edge.
- R8: A write with bit 8 at 1 while force is 1 clears force and raises no NMI. A write with bit 8 at 0 leaves force unchanged.
- R9: Bits 15:13, 10 and 7:0 read as 0 whatever is written. Bits 11 and 9 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low core reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register contents (combinational) |
| nmi_event_in | input | 1 | Incoming NMI event pulse |
| nmi_allow | input | 1 | 1 permits NMI events |
| smi_global_en | input | 1 | Global SMI enable |
| nmi_out | output | 1 | Registered one-cycle NMI request |
| smi_out | output | 1 | Registered one-cycle SMI request |
| wden_wr_inhibit | output | 1 | Blocks writes to the watchdog enable bit |
| cnt_tick_in | input | 1 | Watchdog counter tick |
| cnt_tick_out | output | 1 | Tick gated by halt |
| reboot_in | input | 1 | Reboot request from the watchdog |
| reboot_out | output | 1 | Reboot request gated by halt |
| evmsg_in | input | 1 | Event message request |
| evmsg_out | output | 1 | Event message request gated by halt |
| heartbeat_in | input | 1 | Heartbeat message request |
| heartbeat_out | output | 1 | Heartbeat message request, never gated |

## Verification
Register fields and `wden_wr_inhibit` change at the write edge, and the gated message and tick outputs follow combinationally. The bench therefore reads these at the falling edge right after a write, or about 1 ns after changing an input. `nmi_out` and `smi_out` are registered, so they are checked at the falling edge after the edge that sampled the event or write. They are checked again one cycle later to confirm they have dropped back to 0. A sweep over every single-bit write, and over every redirect/enable/permit and halt/input combination, compares against values computed arithmetically in the bench.

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg #(
  parameter int W         = 16,
  parameter int LOCK_BIT  = 12,
  parameter int HALT_BIT  = 11,
  parameter int REDIR_BIT = 9,
  parameter int FORCE_BIT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         nmi_event_in,
  input  logic         nmi_allow,
  input  logic         smi_global_en,
  output logic         nmi_out,
  output logic         smi_out,
  output logic         wden_wr_inhibit,
  input  logic         cnt_tick_in,
  output logic         cnt_tick_out,
  input  logic         reboot_in,
  output logic         reboot_out,
  input  logic         evmsg_in,
  output logic         evmsg_out,
  input  logic         heartbeat_in,
  output logic         heartbeat_out
);

  logic lock_q, halt_q, redir_q, force_q;
  logic force_set, route_nmi, route_smi;

  assign force_set = wr_en & wr_data[FORCE_BIT] & ~force_q;
  assign route_nmi = nmi_event_in & ~redir_q & nmi_allow;
  assign route_smi = nmi_event_in & redir_q & smi_global_en & nmi_allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      halt_q  <= 1'b0;
      redir_q <= 1'b0;
      force_q <= 1'b0;
      nmi_out <= 1'b0;
      smi_out <= 1'b0;
    end else begin
      if (wr_en) begin
        lock_q  <= lock_q | wr_data[LOCK_BIT];
        halt_q  <= wr_data[HALT_BIT];
        redir_q <= wr_data[REDIR_BIT];
        if (wr_data[FORCE_BIT]) force_q <= ~force_q;
      end
      nmi_out <= force_set | route_nmi;
      smi_out <= route_smi;
    end
  end

  always_comb begin
    rd_data            = '0;
    rd_data[LOCK_BIT]  = lock_q;
    rd_data[HALT_BIT]  = halt_q;
    rd_data[REDIR_BIT] = redir_q;
    rd_data[FORCE_BIT] = force_q;
  end

  assign wden_wr_inhibit = lock_q;
  assign cnt_tick_out    = cnt_tick_in & ~halt_q;
  assign reboot_out      = reboot_in & ~halt_q;
  assign evmsg_out       = evmsg_in & ~halt_q;
  assign heartbeat_out   = heartbeat_in;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[LOCK_BIT] |=> rd_data[LOCK_BIT]) else $error("lock cleared"); // R2
  AST_HALT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick_out || reboot_out || evmsg_out) |-> !rd_data[HALT_BIT]) else $error("halt leak"); // R3
  AST_SMI_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    smi_out |-> $past(smi_global_en)) else $error("smi without global enable"); // R5
  AST_SMI_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    smi_out |-> $past(nmi_allow && rd_data[REDIR_BIT])) else $error("smi not permitted"); // R6
  AST_FORCE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[FORCE_BIT]) |-> nmi_out) else $error("forced nmi missing"); // R7
  AST_FORCE_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_data[FORCE_BIT]) && !$past(nmi_event_in)) |-> !nmi_out) else $error("nmi on clear"); // R8

endmodule

// File: tb/sim_wdog_ctl_reg.sv
module sim_wdog_ctl_reg;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0, rd_data;
  logic nmi_event_in = 0, nmi_allow = 0, smi_global_en = 0;
  logic nmi_out, smi_out, wden_wr_inhibit;
  logic cnt_tick_in = 0, reboot_in = 0, evmsg_in = 0, heartbeat_in = 0;
  logic cnt_tick_out, reboot_out, evmsg_out, heartbeat_out;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_ctl_reg u0 (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_event();
    @(negedge clk); nmi_event_in = 1'b1;
    @(negedge clk); nmi_event_in = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic lock_m, force_m;
    logic [15:0] exp;
    repeat (2) @(negedge clk);
    chk("R1 rd_data", rd_data, 16'h0000);
    chk("R1 outputs", {13'b0, nmi_out, smi_out, wden_wr_inhibit}, 16'h0);
    rst_n = 1'b1;

    // R9 R2 R7 R8 single-bit write sweep with arithmetic model
    lock_m = 0; force_m = 0;
    for (int i = 0; i < 16; i++) begin
      logic fire;
      fire = (i == 8) && !force_m;
      if (i == 8) force_m = ~force_m;
      if (i == 12) lock_m = 1'b1;
      wr(16'(1) << i);
      exp = ((16'(1) << i) & 16'h0A00) | (16'(force_m) << 8) | (16'(lock_m) << 12);
      chk("R9 readback", rd_data, exp);
      chk("R7 pulse", {15'b0, nmi_out}, {15'b0, fire});
      chk("R2 inhibit", {15'b0, wden_wr_inhibit}, {15'b0, lock_m});
      @(negedge clk);
      chk("R7 one cycle", {15'b0, nmi_out}, 16'h0);
    end
    wr(16'hFFFF);
    chk("R9 reserved zero", rd_data & 16'hE4FF, 16'h0);
    wr(16'h0000);
    chk("R2 lock sticks", {15'b0, rd_data[12]}, 16'h1);
    do_reset();
    chk("R2 reset clears lock", rd_data, 16'h0000);
    chk("R2 inhibit off", {15'b0, wden_wr_inhibit}, 16'h0);

    // R7 R8 force sequence
    wr(16'h0100);
    chk("R7 set", {15'b0, rd_data[8]}, 16'h1);
    chk("R7 nmi", {15'b0, nmi_out}, 16'h1);
    wr(16'h0000);
    chk("R8 write0 keeps", {15'b0, rd_data[8]}, 16'h1);
    chk("R8 no nmi", {15'b0, nmi_out}, 16'h0);
    wr(16'h0100);
    chk("R8 clear", {15'b0, rd_data[8]}, 16'h0);
    chk("R8 no nmi on clear", {15'b0, nmi_out}, 16'h0);
    wr(16'h0100);
    chk("R7 re-arm nmi", {15'b0, nmi_out}, 16'h1);
    wr(16'h0100);

    // R4 R5 R6 routing sweep
    for (int c = 0; c < 8; c++) begin
      logic r, s, a;
      r = c[2]; s = c[1]; a = c[0];
      wr({6'b0, r, 9'b0});
      smi_global_en = s; nmi_allow = a;
      pulse_event();
      if (!r) begin
        chk("R4 nmi", {15'b0, nmi_out}, {15'b0, a});
        chk("R4 smi", {15'b0, smi_out}, 16'h0);
      end else if (!s) begin
        chk("R5 smi", {15'b0, smi_out}, 16'h0);
        chk("R5 nmi", {15'b0, nmi_out}, 16'h0);
      end else begin
        chk("R6 smi", {15'b0, smi_out}, {15'b0, a});
        chk("R6 nmi", {15'b0, nmi_out}, 16'h0);
      end
      @(negedge clk);
      chk("R4 R6 one cycle", {14'b0, nmi_out, smi_out}, 16'h0);
    end

    // R3 halt gating sweep
    for (int h = 0; h < 2; h++) begin
      wr(16'(h) << 11);
      for (int v = 0; v < 16; v++) begin
        {cnt_tick_in, reboot_in, evmsg_in, heartbeat_in} = 4'(v);
        #1;
        exp = (h == 1) ? 16'(v & 1) : 16'(v);
        chk("R3 gating", {12'b0, cnt_tick_out, reboot_out, evmsg_out, heartbeat_out}, exp);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule